// File: doc/BRIEF.md
# Analog Clock Movement Pulse Driver

This block produces the two drive lines for a two-terminal stepping movement in an analog clock. A binary prescaler divides the 4.194304 MHz system clock down to a 16 Hz tick. All pulse timing is counted in whole ticks. A drive pulse pulls one of the two lines low for exactly one tick while the other line stays high. Successive pulses alternate between the lines. When no pulse is active, both lines rest high.

Two movement styles are supported:
- **Sweep** (continuous): pulses run back to back, swapping line on every tick, so each line toggles at 8 Hz.
- **Step**: one pulse per second.

A synchronous reset freezes the movement with both lines high and keeps track of which line fired last. On release, the first pulse goes to the other line. In step mode that first pulse comes 1 s plus one tick after release. A power-up indication forces the start-up pattern (line 1 low, line 2 high) and sequencing then continues from there. The mode select is captured only while reset or power-up is asserted.

Top module: `clock_motor_drv`

## Requirements
- R1: One tick lasts 2^TICK_LOG2 clock cycles, counted from the last cycle in which reset or power-up was asserted. With the default TICK_LOG2 = 18 this gives 16 Hz from 4.194304 MHz. Every output transition happens on a tick.
- R2: In sweep mode (modeSel = 0) the pulses run back to back and change line on every tick. Each line is low for one tick and then high for one tick.
- R3: In step mode (modeSel = 1) each pulse is one tick wide. Pulse starts are 16 ticks apart, and the lines alternate.
- R4: Both outputs are high from the first clock edge that samples rst = 1, and they stay high while rst is held.
- R5: In step mode, the first pulse after rst falls starts 17 ticks after release. It goes to the line opposite the one that fired last before reset, including a pulse that reset cut short.
- R6: In sweep mode, the first pulse after rst falls starts 1 tick after release, on the line opposite the one that fired last.
- R7: While powerUp = 1, motO1 = 0 and motO2 = 1, even if rst is also high. After powerUp falls, motO1 stays low for one more tick, and the next pulse goes to motO2.
- R8: modeSel is sampled only on edges where rst or powerUp is high. Changes to it at other times have no effect on the outputs.
- R9: motO1 and motO2 are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 4.194304 MHz |
| rst | input | 1 | Synchronous reset, active high; freezes the movement |
| powerUp | input | 1 | Power-up indication, active high; has priority over rst |
| modeSel | input | 1 | Movement style: 0 = sweep, 1 = step |
| motO1 | output | 1 | Drive line 1; low during its pulse |
| motO2 | output | 1 | Drive line 2; low during its pulse |

## Verification
The outputs are combinational from registers, so a change on rst or powerUp shows on the lines right after the first rising edge that samples it. Tick k after a release lands on rising edge release+k·2^TICK_LOG2, where edge release+1 is the first edge that samples both controls low. The bench counts rising edges from the release point and queues each expected line level against an exact edge number, including the edge just before each predicted transition. It compares the lines at the falling edge that follows that rising edge, so every sample sits half a period clear of any update.

// File: rtl/clock_motor_pkg.sv
package clock_motor_pkg;

  // Strobes from the sequencing control to the timing/output datapath.
  typedef struct packed {
    logic clearDiv;  // hold the prescaler at zero
    logic porLoad;   // load the start-up line choice (line 1)
    logic flip;      // move the active line to the other pin
    logic drive;     // a pulse is currently being driven
  } motCmd_t;

endpackage

// File: rtl/motor_ctrl.sv
module motor_ctrl
  import clock_motor_pkg::*;
#(
  parameter int TICKS_PER_SEC = 16,
  parameter int RESUME_TICKS  = 17
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    powerUp,
  input  logic    modeSel,
  input  logic    tick,
  output motCmd_t cmd,
  output logic    stepMode
);

  localparam int WW = $clog2(RESUME_TICKS + 1);
  localparam logic [WW-1:0] GAP_STEP   = WW'(TICKS_PER_SEC - 1);
  localparam logic [WW-1:0] GAP_RESUME = WW'(RESUME_TICKS);
  localparam logic [WW-1:0] GAP_ONE    = WW'(1);

  logic          modeQ;     // 1 = step, 0 = sweep
  logic          pulseOn;
  logic [WW-1:0] waitLeft;  // ticks remaining before the next pulse start
  logic          running;
  logic          startNow;

  assign running  = !powerUp && !rst;
  assign startNow = !pulseOn && (waitLeft <= GAP_ONE);

  always_ff @(posedge clk) begin
    if (powerUp) begin
      modeQ    <= modeSel;
      pulseOn  <= 1'b1;
      waitLeft <= GAP_ONE;
    end else if (rst) begin
      modeQ    <= modeSel;
      pulseOn  <= 1'b0;
      waitLeft <= modeSel ? GAP_RESUME : GAP_ONE;
    end else if (tick) begin
      if (pulseOn) begin
        if (modeQ) begin
          pulseOn  <= 1'b0;
          waitLeft <= GAP_STEP;
        end
      end else if (startNow) begin
        pulseOn <= 1'b1;
      end else begin
        waitLeft <= waitLeft - GAP_ONE;
      end
    end
  end

  always_comb begin
    cmd.clearDiv = powerUp || rst;
    cmd.porLoad  = powerUp;
    cmd.drive    = pulseOn;
    cmd.flip     = running && tick && ((pulseOn && !modeQ) || startNow);
  end

  assign stepMode = modeQ;

  // R3: a step pulse ends on the first tick after it started
  a_r3_step_one_tick: assert property (@(posedge clk) disable iff (rst || powerUp)
    (modeQ && pulseOn && tick) |=> !pulseOn);

  // R2: in sweep mode, once a pulse is driven, driving never stops
  a_r2_sweep_continuous: assert property (@(posedge clk) disable iff (rst || powerUp)
    (!modeQ && pulseOn) |=> pulseOn);

  // R8: the captured mode does not move outside reset and power-up
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst || powerUp)
    1'b1 |=> $stable(modeQ));

endmodule

// File: rtl/motor_dp.sv
module motor_dp
  import clock_motor_pkg::*;
#(
  parameter int TICK_LOG2 = 18
) (
  input  logic    clk,
  input  motCmd_t cmd,
  output logic    tick,
  output logic    motO1,
  output logic    motO2
);

  logic [TICK_LOG2-1:0] divCnt;
  logic                 curPin;  // 0 = line 1 active/last, 1 = line 2

  always_ff @(posedge clk) begin
    if (cmd.clearDiv) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  assign tick = &divCnt;

  always_ff @(posedge clk) begin
    if (cmd.porLoad)   curPin <= 1'b0;
    else if (cmd.flip) curPin <= !curPin;
  end

  assign motO1 = !(cmd.drive && !curPin);
  assign motO2 = !(cmd.drive && curPin);

  // R9: the two lines are never pulled low together
  a_r9_never_both_low: assert property (@(posedge clk) !(!motO1 && !motO2));

  // R7: power-up forces line 1 low, line 2 high
  a_r7_por_pattern: assert property (@(posedge clk)
    cmd.porLoad |=> (!motO1 && motO2));

  // R4: reset without power-up leaves both lines high
  a_r4_reset_idle: assert property (@(posedge clk)
    (cmd.clearDiv && !cmd.porLoad) |=> (motO1 && motO2));

  // R1: the prescaler restarts from zero after a tick
  a_r1_tick_wrap: assert property (@(posedge clk) disable iff (cmd.clearDiv)
    tick |=> !tick);

endmodule

// File: rtl/clock_motor_drv.sv
module clock_motor_drv
  import clock_motor_pkg::*;
#(
  parameter int TICK_LOG2     = 18,
  parameter int TICKS_PER_SEC = 16,
  parameter int RESUME_TICKS  = TICKS_PER_SEC + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic powerUp,
  input  logic modeSel,
  output logic motO1,
  output logic motO2
);

  motCmd_t cmd;
  logic    tick;
  logic    stepMode;

  motor_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .RESUME_TICKS (RESUME_TICKS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .powerUp (powerUp),
    .modeSel (modeSel),
    .tick    (tick),
    .cmd     (cmd),
    .stepMode(stepMode)
  );

  motor_dp #(
    .TICK_LOG2(TICK_LOG2)
  ) u_dp (
    .clk  (clk),
    .cmd  (cmd),
    .tick (tick),
    .motO1(motO1),
    .motO2(motO2)
  );

  // R2: in sweep mode a tick during a line-1 pulse hands over to line 2
  a_r2_sweep_handover: assert property (@(posedge clk) disable iff (rst || powerUp)
    (!stepMode && tick && !motO1) |=> (motO1 && !motO2));

endmodule

// File: tb/tb_clock_motor_drv.sv
module tb_clock_motor_drv;

  localparam int CLK_PERIOD = 10;
  localparam int TL2 = 4;
  localparam int T   = 1 << TL2;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic powerUp = 1'b1;
  logic modeSel = 1'b1;
  logic motO1, motO2;

  int edgeNo = 0;
  int total = 0;
  int bad = 0;
  int bothLow = 0;

  typedef struct {
    int    at;
    logic  e1;
    logic  e2;
    string req;
  } expItem_t;

  expItem_t q[$];

  clock_motor_drv #(.TICK_LOG2(TL2)) dut (
    .clk(clk), .rst(rst), .powerUp(powerUp), .modeSel(modeSel),
    .motO1(motO1), .motO2(motO2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) edgeNo <= edgeNo + 1;

  task automatic expectAt(input int at, input logic e1, input logic e2, input string req);
    expItem_t it;
    it.at = at; it.e1 = e1; it.e2 = e2; it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare queued expectations at the falling edge after their rising edge.
  always @(negedge clk) begin
    if (!motO1 && !motO2) bothLow++;
    while (q.size() > 0 && q[0].at <= edgeNo) begin
      expItem_t it;
      it = q.pop_front();
      total++;
      if (it.at != edgeNo || motO1 !== it.e1 || motO2 !== it.e2) begin
        bad++;
        $display("FAIL %s edge=%0d(now %0d): got O1=%b O2=%b expected O1=%b O2=%b",
                 it.req, it.at, edgeNo, motO1, motO2, it.e1, it.e2);
      end
    end
  end

  task automatic runAll();
    int base;
    // Power-up in step mode (R7)
    @(negedge clk); @(negedge clk);
    expectAt(edgeNo + 1, 1'b0, 1'b1, "R7");
    @(negedge clk);
    powerUp = 1'b0;
    base = edgeNo;
    expectAt(base + T - 1,  1'b0, 1'b1, "R7");
    expectAt(base + T,      1'b1, 1'b1, "R3");
    expectAt(base + 16*T-1, 1'b1, 1'b1, "R3");
    expectAt(base + 16*T,   1'b1, 1'b0, "R7");
    expectAt(base + 17*T-1, 1'b1, 1'b0, "R3");
    expectAt(base + 17*T,   1'b1, 1'b1, "R3");
    expectAt(base + 32*T,   1'b0, 1'b1, "R8");  // still step timing after modeSel moved
    repeat (3) @(negedge clk);
    modeSel = 1'b0;  // ignored while running (R8)
    drain();
    // Now line 1 is pulsing; reset mid-pulse in step mode (R4, R5)
    modeSel = 1'b1;
    rst = 1'b1;
    expectAt(edgeNo + 1,      1'b1, 1'b1, "R4");
    expectAt(edgeNo + 20*T,   1'b1, 1'b1, "R4");
    repeat (20*T) @(negedge clk);
    rst = 1'b0;
    base = edgeNo;
    expectAt(base + 17*T-1, 1'b1, 1'b1, "R5");
    expectAt(base + 17*T,   1'b1, 1'b0, "R5");
    expectAt(base + 18*T,   1'b1, 1'b1, "R3");
    expectAt(base + 33*T,   1'b0, 1'b1, "R3");
    drain();
    // Sweep mode after reset, last line was line 1 (R6, R2)
    rst = 1'b1;
    modeSel = 1'b0;
    expectAt(edgeNo + 1, 1'b1, 1'b1, "R4");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    base = edgeNo;
    expectAt(base + T - 1,  1'b1, 1'b1, "R6");
    expectAt(base + T,      1'b1, 1'b0, "R6");
    expectAt(base + 2*T-1,  1'b1, 1'b0, "R2");
    expectAt(base + 2*T,    1'b0, 1'b1, "R2");
    expectAt(base + 3*T,    1'b1, 1'b0, "R2");
    expectAt(base + 4*T,    1'b0, 1'b1, "R2");
    expectAt(base + 5*T,    1'b1, 1'b0, "R8");
    expectAt(base + 16*T,   1'b0, 1'b1, "R8");
    expectAt(base + 17*T,   1'b1, 1'b0, "R1");
    @(negedge clk);
    modeSel = 1'b1;  // ignored while running (R8)
    drain();
    // Line 2 pulsing in sweep; reset into step mode (R4, R5)
    rst = 1'b1;
    expectAt(edgeNo + 1, 1'b1, 1'b1, "R4");
    repeat (2) @(negedge clk);
    rst = 1'b0;
    base = edgeNo;
    expectAt(base + 17*T-1, 1'b1, 1'b1, "R5");
    expectAt(base + 17*T,   1'b0, 1'b1, "R5");
    expectAt(base + 18*T,   1'b1, 1'b1, "R3");
    drain();
    // Power-up overrides reset, sweep mode (R7, R2)
    rst = 1'b1;
    powerUp = 1'b1;
    modeSel = 1'b0;
    expectAt(edgeNo + 1, 1'b0, 1'b1, "R7");
    repeat (2) @(negedge clk);
    powerUp = 1'b0;
    rst = 1'b0;
    base = edgeNo;
    expectAt(base + T - 1, 1'b0, 1'b1, "R7");
    expectAt(base + T,     1'b1, 1'b0, "R7");
    expectAt(base + 2*T,   1'b0, 1'b1, "R2");
    drain();
    // R9: lines never both low during the whole run
    total++;
    if (bothLow != 0) begin
      bad++;
      $display("FAIL R9: both-low cycles got %0d expected 0", bothLow);
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule